// File: doc/BRIEF.md
# Column Multi-Sampling Counter with Digital Double-Sample Subtraction

This block is the digital back end of one column of a single-slope converter that samples each pixel several times. A comparator output arrives together with a conversion-window qualifier. While both are high, an up-counter advances once per counter clock. The counter accumulates over all reset-level conversions, and the total is captured into a reset latch. It then accumulates over the signal-level conversions, and that total is captured into a signal latch. The output word subtracts the two after each is weighted by its ramp and its sample count, so the offset common to both phases cancels.

The signal phase begins on the default full-range ramp. Once the column's comparator has flipped, an external selector reports which of four ramps suits the pixel. On the default ramp, counting simply continues, which gives two signal samples. On any steeper ramp, the counter restarts, so the selection slot is not counted and 3, 7 or 15 samples remain. Each count on ramp k is worth 2^(4-k) of the finest step. The result is brought to a common base of 210 samples, so the output scale is the same whichever ramp a pixel used.

Top module: `cds_column`

## Requirements
- R1: A cycle with `cnt_clr` high zeroes the counter and returns the recorded ramp to code 0. This overrides every other control in the same cycle, and a comparator count in that cycle is lost.
- R2: The counter adds exactly 1 per clock in which `conv_win` and `cmp_hi` are both high. `cmp_hi` high while `conv_win` is low has no effect on the count.
- R3: Counts accumulate across consecutive conversion windows with no clear between them. The counter never wraps at full scale: at the default parameters that is 2 slots of 4096 counts on the default ramp, 2 reset slots of 4096, or 15 slots of 512 on ramp 4.
- R4: A cycle with `rst_cap` high copies the counter into the reset total and restarts the counter from zero. A comparator count in that cycle is lost.
- R5: A cycle with `sig_cap` high copies the counter into the signal total. `pix_vld` is high for exactly the one clock that follows and is low otherwise.
- R6: A cycle with `ramp_load` high records `ramp_code`. Codes 0, 1, 2 and 3 select ramps 1 (default full range), 2, 3 and 4. A nonzero code also zeroes the counter and drops that cycle's count. Code 0 leaves the counter running, and a count in that cycle is kept.
- R7: `pix_val` = signal total × Wk − reset total × 840, where Wk is 840, 280, 60 and 14 for codes 0 to 3. Each Wk is the per-count weight (8, 4, 2, 1) times 210 divided by the sample count (2, 3, 7, 15). The reset term is 8 × 210 / 2.
- R8: `pix_val` is a 24-bit two's-complement value. It is exact at the full-scale corners, including the most negative case: 8192 reset counts against an empty signal.
- R9: After reset, `pix_vld` is 0 and `pix_val` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_clr | input | 1 | Start of pixel: zero counter, default ramp |
| conv_win | input | 1 | High while a conversion slot is running |
| cmp_hi | input | 1 | Comparator output |
| ramp_load | input | 1 | Ramp choice for this column is valid |
| ramp_code | input | 2 | Chosen ramp, 0 = default full-range |
| rst_cap | input | 1 | Capture reset total, restart counter |
| sig_cap | input | 1 | Capture signal total |
| pix_val | output | 24 | Signed normalised pixel difference |
| pix_vld | output | 1 | One-clock pulse after the signal capture |

## Verification
The hardest situations to reach are those where a comparator count lands on the same edge as a counter restart: a clear, a reset capture or a ramp switch. A single dropped or extra count there changes the result by a whole weight. The stimulus can force the comparator and window high in exactly those cycles, so each can be steered there. Random pixels spread over all four ramps and include stray comparator pulses outside the windows. Directed full-scale pixels fill every slot to its length to reach the largest positive and most negative outputs.

// File: rtl/cds_pkg.sv
package cds_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_INC  = 2'd1,
        ACT_ZERO = 2'd2
    } cnt_act_e;

    // counted signal samples for ramp index k (0 = default ramp)
    function automatic int samples_of(input int k);
        return (k == 0) ? 2 : ((1 << (k + 1)) - 1);
    endfunction

    function automatic int gcd_of(input int a, input int b);
        int x;
        int y;
        int t;
        x = a;
        y = b;
        while (y != 0) begin
            t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    function automatic int lcm_of(input int a, input int b);
        return (a / gcd_of(a, b)) * b;
    endfunction

    // common sample base all ramps are normalised to
    function automatic int common_len(input int nr, input int nramps);
        int l;
        l = nr;
        for (int k = 0; k < nramps; k++) begin
            l = lcm_of(l, samples_of(k));
        end
        return l;
    endfunction

    // value of one count on ramp k, in finest-ramp steps
    function automatic int step_of(input int k, input int nramps);
        return 1 << (nramps - 1 - k);
    endfunction

    function automatic int sig_weight(input int k, input int nr, input int nramps);
        return step_of(k, nramps) * (common_len(nr, nramps) / samples_of(k));
    endfunction

    function automatic int rst_weight(input int nr, input int nramps);
        return step_of(0, nramps) * (common_len(nr, nramps) / nr);
    endfunction

    // longest comparator-high run in one slot of ramp k
    function automatic int slot_len(input int k, input int res);
        return 1 << (res - k);
    endfunction

    function automatic int cnt_width(input int res, input int nr, input int nramps);
        longint m;
        m = longint'(nr) * slot_len(0, res);
        for (int k = 0; k < nramps; k++) begin
            longint p;
            p = longint'(samples_of(k)) * slot_len(k, res);
            if (p > m) m = p;
        end
        return $clog2(m + 1);
    endfunction

    function automatic int out_width(input int res, input int nr, input int nramps);
        longint m;
        m = longint'(nr) * slot_len(0, res) * rst_weight(nr, nramps);
        for (int k = 0; k < nramps; k++) begin
            longint p;
            p = longint'(samples_of(k)) * slot_len(k, res) * sig_weight(k, nr, nramps);
            if (p > m) m = p;
        end
        return $clog2(m + 1) + 1;
    endfunction

endpackage

// File: rtl/cds_counter.sv
module cds_counter
    import cds_pkg::*;
#(
    parameter int CNT_W  = 14,
    parameter int RSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_clr,
    input  logic              rst_cap,
    input  logic              conv_win,
    input  logic              cmp_hi,
    input  logic              ramp_load,
    input  logic [RSEL_W-1:0] ramp_code,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [RSEL_W-1:0] ramp_q
);

    cnt_act_e act;

    // restart sources outrank the comparator
    always_comb begin
        if (cnt_clr || rst_cap) begin
            act = ACT_ZERO;
        end else if (ramp_load && (ramp_code != '0)) begin
            act = ACT_ZERO;
        end else if (conv_win && cmp_hi) begin
            act = ACT_INC;
        end else begin
            act = ACT_HOLD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            case (act)
                ACT_ZERO: cnt_q <= '0;
                ACT_INC:  cnt_q <= cnt_q + CNT_W'(1);
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || cnt_clr) begin
            ramp_q <= '0;
        end else if (ramp_load) begin
            ramp_q <= ramp_code;
        end
    end

endmodule

// File: rtl/cds_capture.sv
module cds_capture #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rst_cap,
    input  logic             sig_cap,
    input  logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] rst_tot,
    output logic [CNT_W-1:0] sig_tot,
    output logic             done
);

    typedef struct packed {
        logic [CNT_W-1:0] rst_sum;
        logic [CNT_W-1:0] sig_sum;
    } totals_t;

    totals_t tot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tot_q <= '0;
            done  <= 1'b0;
        end else begin
            if (rst_cap) tot_q.rst_sum <= cnt_q;
            if (sig_cap) tot_q.sig_sum <= cnt_q;
            done <= sig_cap;
        end
    end

    assign rst_tot = tot_q.rst_sum;
    assign sig_tot = tot_q.sig_sum;

endmodule

// File: rtl/cds_scale.sv
module cds_scale
    import cds_pkg::*;
#(
    parameter int CNT_W     = 14,
    parameter int RSEL_W    = 2,
    parameter int NUM_RAMPS = 4,
    parameter int N_RST     = 2,
    parameter int OUT_W     = 24
) (
    input  logic [CNT_W-1:0]  rst_tot,
    input  logic [CNT_W-1:0]  sig_tot,
    input  logic [RSEL_W-1:0] ramp_q,
    output logic [OUT_W-1:0]  pix
);

    localparam int W_RST = rst_weight(N_RST, NUM_RAMPS);

    logic [OUT_W-1:0] wtab [NUM_RAMPS];
    logic [OUT_W-1:0] wsel;
    logic [OUT_W-1:0] sig_term;
    logic [OUT_W-1:0] rst_term;

    for (genvar g = 0; g < NUM_RAMPS; g++) begin : g_wt
        assign wtab[g] = OUT_W'(sig_weight(g, N_RST, NUM_RAMPS));
    end

    always_comb begin
        wsel = '0;
        for (int k = 0; k < NUM_RAMPS; k++) begin
            if (int'(ramp_q) == k) wsel = wtab[k];
        end
    end

    assign sig_term = OUT_W'(sig_tot) * wsel;
    assign rst_term = OUT_W'(rst_tot) * OUT_W'(W_RST);
    assign pix      = sig_term - rst_term;

endmodule

// File: rtl/cds_column.sv
module cds_column
    import cds_pkg::*;
#(
    parameter int RES       = 12,
    parameter int N_RST     = 2,
    parameter int NUM_RAMPS = 4,
    localparam int RSEL_W   = (NUM_RAMPS > 1) ? $clog2(NUM_RAMPS) : 1,
    localparam int CNT_W    = cnt_width(RES, N_RST, NUM_RAMPS),
    localparam int OUT_W    = out_width(RES, N_RST, NUM_RAMPS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_clr,
    input  logic              conv_win,
    input  logic              cmp_hi,
    input  logic              ramp_load,
    input  logic [RSEL_W-1:0] ramp_code,
    input  logic              rst_cap,
    input  logic              sig_cap,
    output logic [OUT_W-1:0]  pix_val,
    output logic              pix_vld
);

    logic [CNT_W-1:0]  cnt_q;
    logic [RSEL_W-1:0] ramp_q;
    logic [CNT_W-1:0]  rst_tot;
    logic [CNT_W-1:0]  sig_tot;

    cds_counter #(
        .CNT_W (CNT_W),
        .RSEL_W(RSEL_W)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .cnt_clr  (cnt_clr),
        .rst_cap  (rst_cap),
        .conv_win (conv_win),
        .cmp_hi   (cmp_hi),
        .ramp_load(ramp_load),
        .ramp_code(ramp_code),
        .cnt_q    (cnt_q),
        .ramp_q   (ramp_q)
    );

    cds_capture #(
        .CNT_W(CNT_W)
    ) u_cap (
        .clk    (clk),
        .rst    (rst),
        .rst_cap(rst_cap),
        .sig_cap(sig_cap),
        .cnt_q  (cnt_q),
        .rst_tot(rst_tot),
        .sig_tot(sig_tot),
        .done   (pix_vld)
    );

    cds_scale #(
        .CNT_W    (CNT_W),
        .RSEL_W   (RSEL_W),
        .NUM_RAMPS(NUM_RAMPS),
        .N_RST    (N_RST),
        .OUT_W    (OUT_W)
    ) u_scl (
        .rst_tot(rst_tot),
        .sig_tot(sig_tot),
        .ramp_q (ramp_q),
        .pix    (pix_val)
    );

endmodule

// File: rtl/cds_column_chk.sv
module cds_column_chk #(
    parameter int CNT_W  = 14,
    parameter int RSEL_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cnt_clr,
    input logic              conv_win,
    input logic              cmp_hi,
    input logic              ramp_load,
    input logic [RSEL_W-1:0] ramp_code,
    input logic              rst_cap,
    input logic              sig_cap,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [RSEL_W-1:0] ramp_q,
    input logic [CNT_W-1:0]  rst_tot,
    input logic [CNT_W-1:0]  sig_tot,
    input logic              pix_vld
);

    logic hit;
    logic restart;
    assign hit     = conv_win && cmp_hi;
    assign restart = cnt_clr || rst_cap || (ramp_load && (ramp_code != '0));

    a_r1_clear: assert property (@(posedge clk) disable iff (rst)
        cnt_clr |=> (cnt_q == '0) && (ramp_q == '0));

    a_r2_count: assert property (@(posedge clk) disable iff (rst)
        (hit && !restart) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

    a_r2_idle: assert property (@(posedge clk) disable iff (rst)
        (!hit && !restart) |=> $stable(cnt_q));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (hit && !restart) |-> cnt_q != '1);

    a_r4_rst_capture: assert property (@(posedge clk) disable iff (rst)
        rst_cap |=> (rst_tot == $past(cnt_q)) && (cnt_q == '0));

    a_r5_sig_capture: assert property (@(posedge clk) disable iff (rst)
        sig_cap |=> (sig_tot == $past(cnt_q)) && pix_vld);

    a_r5_pulse: assert property (@(posedge clk) disable iff (rst)
        !sig_cap |=> !pix_vld);

    a_r6_switch: assert property (@(posedge clk) disable iff (rst)
        (ramp_load && !cnt_clr) |=> ramp_q == $past(ramp_code));

    a_r6_restart: assert property (@(posedge clk) disable iff (rst)
        (ramp_load && (ramp_code != '0)) |=> cnt_q == '0);

endmodule

bind cds_column cds_column_chk #(
    .CNT_W (CNT_W),
    .RSEL_W(RSEL_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cnt_clr  (cnt_clr),
    .conv_win (conv_win),
    .cmp_hi   (cmp_hi),
    .ramp_load(ramp_load),
    .ramp_code(ramp_code),
    .rst_cap  (rst_cap),
    .sig_cap  (sig_cap),
    .cnt_q    (cnt_q),
    .ramp_q   (ramp_q),
    .rst_tot  (rst_tot),
    .sig_tot  (sig_tot),
    .pix_vld  (pix_vld)
);

// File: tb/cds_column_tb.sv
`timescale 1ns/1ps
module cds_column_tb;

    localparam int NR = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_clr = 1'b0;
    logic        conv_win = 1'b0;
    logic        cmp_hi = 1'b0;
    logic        ramp_load = 1'b0;
    logic [1:0]  ramp_code = 2'd0;
    logic        rst_cap = 1'b0;
    logic        sig_cap = 1'b0;
    logic [23:0] pix_val;
    logic        pix_vld;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    cds_column u_dut (
        .clk      (clk),
        .rst      (rst),
        .cnt_clr  (cnt_clr),
        .conv_win (conv_win),
        .cmp_hi   (cmp_hi),
        .ramp_load(ramp_load),
        .ramp_code(ramp_code),
        .rst_cap  (rst_cap),
        .sig_cap  (sig_cap),
        .pix_val  (pix_val),
        .pix_vld  (pix_vld)
    );

    function automatic int samp(input int code);
        return (code == 0) ? 2 : ((1 << (code + 1)) - 1);
    endfunction

    // R7: weight per signal count, common base of 210 samples
    function automatic longint wsig(input int code);
        return longint'((8 >> code) * 210 / samp(code));
    endfunction

    function automatic longint expect_pix(input int code, input longint s, input longint r);
        return s * wsig(code) - r * 840;
    endfunction

    task automatic check(input string tag, input string what, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic drive(input bit w, input bit c);
        conv_win = w;
        cmp_hi   = c;
        @(negedge clk);
    endtask

    task automatic slot(input int hi, input bit stray);
        if (stray) begin
            drive(1'b0, 1'b1);
            drive(1'b0, 1'b1);
        end
        drive(1'b1, 1'b0);
        for (int i = 0; i < hi; i++) drive(1'b1, 1'b1);
        drive(1'b0, 1'b0);
    endtask

    function automatic int pick(input int lim, input bit full);
        return full ? lim : int'($urandom_range(lim, 0));
    endfunction

    task automatic run_pixel(input string tag, input int code, input int rlim, input int slim,
                             input bit full, input bit stray, input bit hit_clr,
                             input bit hit_cap, input bit hit_load);
        longint rsum;
        longint ssum;
        int     c;
        int     slim_k;
        int     nrest;
        slim_k = (slim < (4096 >> code)) ? slim : (4096 >> code);
        // R1: clear, optionally with a comparator count on the same edge
        cnt_clr = 1'b1;
        drive(hit_clr, hit_clr);
        cnt_clr = 1'b0;
        rsum = 0;
        for (int i = 0; i < NR; i++) begin
            c = pick(rlim, full);
            rsum += c;
            slot(c, stray);
        end
        // R4: capture reset total, count on this edge is lost
        rst_cap = 1'b1;
        drive(hit_cap, hit_cap);
        rst_cap = 1'b0;
        c = pick(slim_k, full);
        slot(c, stray);
        ssum = (code == 0) ? longint'(c) : 0;
        // R6: ramp choice; count kept only on the default ramp
        ramp_load = 1'b1;
        ramp_code = 2'(code);
        drive(hit_load, hit_load);
        ramp_load = 1'b0;
        if (code == 0 && hit_load) ssum += 1;
        nrest = (code == 0) ? 1 : samp(code);
        for (int i = 0; i < nrest; i++) begin
            c = pick(slim_k, full);
            ssum += c;
            slot(c, stray);
        end
        sig_cap = 1'b1;
        drive(1'b0, 1'b0);
        sig_cap = 1'b0;
        check("R5", "pix_vld after capture", longint'(pix_vld), 1);
        check(tag, "pix_val", longint'($signed(pix_val)), expect_pix(code, ssum, rsum));
        drive(1'b0, 1'b0);
        check("R5", "pix_vld one cycle later", longint'(pix_vld), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9", "pix_vld after reset", longint'(pix_vld), 0);
        check("R9", "pix_val after reset", longint'($signed(pix_val)), 0);

        // directed corners
        run_pixel("R1", 0, 0, 0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        run_pixel("R1", 2, 20, 20, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        run_pixel("R2", 1, 30, 30, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        run_pixel("R4", 0, 25, 25, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        run_pixel("R6", 0, 10, 10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        run_pixel("R6", 2, 10, 10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        run_pixel("R3", 0, 4096, 4096, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        run_pixel("R3", 3, 0, 512, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        run_pixel("R8", 3, 4096, 0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);

        // R7: random pixels across all ramps
        for (int p = 0; p < 40; p++) begin
            run_pixel("R7", int'($urandom_range(3, 0)), 40, 40, 1'b0,
                      1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)),
                      1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule